// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, in the same cycle and with no internal state, whether one memory access may proceed under a set of up to sixteen protection regions. Each region is described by an 8-bit configuration byte and an address register. The address register holds a word address, which is the physical byte address shifted right by two. The checker receives the byte address of the access and the kind of access: read, write or instruction fetch. An atomic read-modify-write raises both read and write. It also receives the current privilege level and the packed configuration and address contents of all regions. It returns three fault flags, for load, store and instruction fetch, which the surrounding trap logic turns into access exceptions.

Every region compares the word address against its own bounds in parallel. The mode of a region can be off, top-of-range, a single naturally aligned word, or a naturally aligned power-of-two range. The lowest-numbered region that matches supplies the permissions. A small evaluation stage then combines those permissions with the privilege level and the lock bit of that region. An atomic access that hits a region without read permission reports only a store fault. A load fault never appears on an access that also writes.

Top module: `pmp_access_checker`

## Requirements
- R1: A region whose mode field (bits 4:3 of its configuration byte) is 00 (off) never matches. When every region is off, no access at any privilege level faults.
- R2: Mode 01 (top-of-range): region i matches when the word address (byte address bits above bit 1) is at least address register i-1 and below address register i. Region 0 uses zero as its lower bound, and region 8 takes its lower bound from region 7. Region n's configuration byte sits at bits 8n+7:8n of `cfg_bank`, and its address register sits at bits AW*n+AW-1:AW*n of `addr_bank`.
- R3: Mode 10 (single word) matches exactly the one 4-byte word whose word address equals the address register. The two low byte-address bits are ignored.
- R4: Mode 11 (power-of-two range) with t trailing ones in the address register matches a naturally aligned block of 2^(t+3) bytes. The block's base is the register with those t+1 low bits cleared.
- R5: When several regions match, only the lowest-numbered matching region decides the permissions.
- R6: `fault_load` is raised only when enforcement is active, the access reads and does not write, and the deciding region lacks read permission (bit 0). An atomic access (read and write both set) never raises it.
- R7: `fault_store` is raised when enforcement is active, the access writes, and the deciding region lacks write permission (bit 1). An atomic access to an execute-only region therefore gives a store fault only.
- R8: `fault_fetch` is raised when enforcement is active, the access is a fetch, and the deciding region lacks execute permission (bit 2).
- R9: In supervisor mode (`priv_mode` 01) or user mode (00), enforcement is always active. An access that matches no region faults for every kind it performs, provided at least one region is not off.
- R10: In machine mode (`priv_mode` 11), an access that matches no region, or whose deciding region has its lock bit (bit 7) clear, raises no fault. A deciding region with the lock bit set is enforced as in R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_mode | input | 2 | Current privilege level: 11 machine, 01 supervisor, 00 user |
| phys_addr | input | PA_W | Physical byte address of the access |
| acc_rd | input | 1 | Access reads (set together with acc_wr for atomics) |
| acc_wr | input | 1 | Access writes |
| acc_ex | input | 1 | Access is an instruction fetch |
| cfg_bank | input | NREG*8 | Configuration bytes, region n in bits 8n+7:8n |
| addr_bank | input | NREG*AW | Address registers (word addresses), region n in slice n |
| fault_load | output | 1 | Load access fault |
| fault_store | output | 1 | Store or atomic access fault |
| fault_fetch | output | 1 | Instruction fetch access fault |

## Verification
The block holds no state, so any wrong internal value shows at the fault outputs as soon as the inputs settle. The usual internal errors are a wrong region hit, a wrong winner index or a misread permission bit. Each of these changes a fault flag only for certain addresses and modes. The tests therefore sit on the exact edges of every region: one word below and one word at each top-of-range bound, both ends of a power-of-two block, and neighbouring words of a single-word region. They also place overlapping regions so that a wrong priority winner flips the result. A fault from the atomic path would show up as a spurious load flag, and a mis-gated lock bit would show up only in machine-mode accesses. Each of these cases is therefore driven at both privilege levels.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'b00,
    AM_TOR   = 2'b01,
    AM_NA4   = 2'b10,
    AM_NAPOT = 2'b11
  } amode_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } rcfg_t;

  localparam logic [1:0] PRIV_USER  = 2'b00;
  localparam logic [1:0] PRIV_SUPER = 2'b01;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] word_addr,
  input  logic [AW-1:0] lo_bound,
  input  logic [AW-1:0] hi_reg,
  input  amode_e        mode,
  output logic          hit
);

  logic [AW-1:0] napot_mask;

  always_comb begin
    napot_mask = hi_reg ^ (hi_reg + AW'(1));
    unique case (mode)
      AM_TOR:   hit = (word_addr >= lo_bound) && (word_addr < hi_reg);
      AM_NA4:   hit = (word_addr == hi_reg);
      AM_NAPOT: hit = ((word_addr ^ hi_reg) & ~napot_mask) == '0;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == AM_OFF) begin
      AST_OFF_NEVER_HITS: assert (!hit); // R1
    end
    if (mode == AM_NA4 && hit) begin
      AST_NA4_EXACT_WORD: assert (word_addr == hi_reg); // R3
    end
    if (mode == AM_TOR && hit) begin
      AST_TOR_BELOW_TOP: assert (word_addr < hi_reg); // R2
    end
  end

endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = 4
) (
  input  logic [NREG-1:0]  hits,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      AST_WINNER_HITS: assert (hits[win_idx]); // R5
      for (int j = 0; j < NREG; j++) begin
        if (j < int'(win_idx)) begin
          AST_NO_LOWER_HIT: assert (!hits[j]); // R5
        end
      end
    end else begin
      AST_NONE_MEANS_EMPTY: assert (hits == '0); // R5
    end
  end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  logic [1:0] priv_mode,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic       acc_ex,
  input  logic       any_hit,
  input  logic       any_active,
  input  logic       win_lock,
  input  logic       win_r,
  input  logic       win_w,
  input  logic       win_x,
  output logic       fault_load,
  output logic       fault_store,
  output logic       fault_fetch
);

  logic enforce;
  logic deny_r, deny_w, deny_x;

  always_comb begin
    enforce = (priv_mode != PRIV_MACH) || (any_hit && win_lock);
    if (any_hit) begin
      deny_r = !win_r;
      deny_w = !win_w;
      deny_x = !win_x;
    end else begin
      deny_r = any_active;
      deny_w = any_active;
      deny_x = any_active;
    end
    fault_load  = enforce && acc_rd && !acc_wr && deny_r;
    fault_store = enforce && acc_wr && deny_w;
    fault_fetch = enforce && acc_ex && deny_x;
  end

  always_comb begin
    AST_NO_LOAD_ON_WRITE: assert (!(fault_load && acc_wr)); // R6
    if (priv_mode == PRIV_MACH && !(any_hit && win_lock)) begin
      AST_MACH_UNLOCKED_FREE: assert (!fault_load && !fault_store && !fault_fetch); // R10
    end
    if (priv_mode != PRIV_MACH && !any_hit && any_active) begin
      AST_SU_MISS_FAULTS: assert (fault_store == acc_wr && fault_fetch == acc_ex); // R9
    end
    if (any_hit && win_w) begin
      AST_WRITE_ALLOWED: assert (!fault_store); // R7
    end
    if (any_hit && win_x) begin
      AST_EXEC_ALLOWED: assert (!fault_fetch); // R8
    end
  end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int NREG = 16,
  parameter int PA_W = 34,
  parameter int AW   = PA_W - 2
) (
  input  logic [1:0]         priv_mode,
  input  logic [PA_W-1:0]    phys_addr,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic               acc_ex,
  input  logic [NREG*8-1:0]  cfg_bank,
  input  logic [NREG*AW-1:0] addr_bank,
  output logic               fault_load,
  output logic               fault_store,
  output logic               fault_fetch
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  rcfg_t             cfg_arr [NREG];
  logic [AW-1:0]     areg    [NREG];
  logic [NREG-1:0]   hits;
  logic [NREG-1:0]   active;
  logic [AW-1:0]     word_addr;
  logic              any_hit;
  logic              any_active;
  logic [IDX_W-1:0]  win_idx;
  rcfg_t             win_cfg;
  logic              unused_bits;

  assign word_addr = phys_addr[PA_W-1:2];

  for (genvar n = 0; n < NREG; n++) begin : g_region
    logic [AW-1:0] lo_bound;

    assign cfg_arr[n] = rcfg_t'(cfg_bank[8*n +: 8]);
    assign areg[n]    = addr_bank[AW*n +: AW];
    assign active[n]  = (cfg_arr[n].mode != AM_OFF);

    if (n == 0) begin : g_first
      assign lo_bound = '0;
    end else begin : g_rest
      assign lo_bound = addr_bank[AW*(n-1) +: AW];
    end

    pmp_region_match #(.AW(AW)) u_match (
      .word_addr (word_addr),
      .lo_bound  (lo_bound),
      .hi_reg    (areg[n]),
      .mode      (cfg_arr[n].mode),
      .hit       (hits[n])
    );
  end

  assign any_active = |active;

  pmp_prio_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .hits    (hits),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  assign win_cfg     = cfg_arr[win_idx];
  assign unused_bits = ^{phys_addr[1:0], win_cfg.rsvd, win_cfg.mode};

  pmp_perm_eval u_eval (
    .priv_mode   (priv_mode),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_ex      (acc_ex),
    .any_hit     (any_hit),
    .any_active  (any_active),
    .win_lock    (win_cfg.lock),
    .win_r       (win_cfg.r),
    .win_w       (win_cfg.w),
    .win_x       (win_cfg.x),
    .fault_load  (fault_load),
    .fault_store (fault_store),
    .fault_fetch (fault_fetch)
  );

  always_comb begin
    if (any_hit) begin
      AST_WINNER_IS_ACTIVE: assert (active[win_idx]); // R1
    end
    if (!any_active) begin
      AST_ALL_OFF_NO_FAULT: assert (!fault_load && !fault_store && !fault_fetch); // R1
    end
  end

endmodule

// File: tb/pmp_access_checker_test.sv
module pmp_access_checker_test;
  localparam int  NREG = 16;
  localparam int  PA_W = 34;
  localparam int  AW   = PA_W - 2;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [1:0] PU = 2'b00;
  localparam logic [1:0] PS = 2'b01;
  localparam logic [1:0] PM = 2'b11;

  logic clk;
  logic rst_n;
  logic [1:0]         priv_mode;
  logic [PA_W-1:0]    phys_addr;
  logic               acc_rd, acc_wr, acc_ex;
  logic [NREG*8-1:0]  cfg_bank;
  logic [NREG*AW-1:0] addr_bank;
  logic               fault_load, fault_store, fault_fetch;

  logic [7:0]    cfgs  [NREG];
  logic [AW-1:0] aregs [NREG];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pmp_access_checker #(.NREG(NREG), .PA_W(PA_W)) uut (
    .priv_mode   (priv_mode),
    .phys_addr   (phys_addr),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_ex      (acc_ex),
    .cfg_bank    (cfg_bank),
    .addr_bank   (addr_bank),
    .fault_load  (fault_load),
    .fault_store (fault_store),
    .fault_fetch (fault_fetch)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic clear_regions();
    for (int i = 0; i < NREG; i++) begin
      cfgs[i]  = 8'h00;
      aregs[i] = '0;
    end
  endtask

  task automatic load_banks();
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      cfg_bank[8*i +: 8]   = cfgs[i];
      addr_bank[AW*i +: AW] = aregs[i];
    end
  endtask

  // kind: "r" read, "w" write, "a" atomic, "x" fetch
  task automatic probe(input string req, input logic [1:0] pv, input logic [PA_W-1:0] a,
                       input byte kind, input logic el, input logic es, input logic ef);
    @(negedge clk);
    priv_mode = pv;
    phys_addr = a;
    acc_rd = (kind == "r") || (kind == "a");
    acc_wr = (kind == "w") || (kind == "a");
    acc_ex = (kind == "x");
    #1;
    checks++;
    if ({fault_load, fault_store, fault_fetch} !== {el, es, ef}) begin
      fails++;
      $display("FAIL %s addr=%h kind=%c priv=%b: got ld/st/if=%b%b%b expected %b%b%b",
               req, a, kind, pv, fault_load, fault_store, fault_fetch, el, es, ef);
    end
  endtask

  task automatic t_all_off();
    clear_regions();
    load_banks();
    probe("R1", PS, 34'h0_8000_0000, "r", 0, 0, 0);
    probe("R1", PU, 34'h0_0000_1234, "w", 0, 0, 0);
    probe("R1", PM, 34'h3_FFFF_FFFC, "x", 0, 0, 0);
  endtask

  task automatic t_tor();
    clear_regions();
    cfgs[0] = 8'h09; aregs[0] = 32'h100;           // TOR, read only, words [0,0x100)
    load_banks();
    probe("R2", PS, 34'h3FC, "r", 0, 0, 0);
    probe("R2", PS, 34'h000, "w", 0, 1, 0);
    probe("R2", PS, 34'h400, "r", 1, 0, 0);       // miss -> R9
    clear_regions();
    aregs[0] = 32'h100; aregs[1] = 32'h200; cfgs[1] = 8'h0F;
    load_banks();
    probe("R2", PS, 34'h400, "r", 0, 0, 0);
    probe("R2", PS, 34'h3FC, "r", 1, 0, 0);
    probe("R2", PS, 34'h7FC, "x", 0, 0, 0);
    probe("R2", PS, 34'h800, "x", 0, 0, 1);
    clear_regions();                               // region 8 bounded by region 7
    aregs[7] = 32'h1000; aregs[8] = 32'h1004; cfgs[8] = 8'h0F;
    load_banks();
    probe("R2", PU, 34'h4000, "x", 0, 0, 0);
    probe("R2", PU, 34'h3FFC, "x", 0, 0, 1);
    clear_regions();                               // region 15 in the upper bank
    aregs[14] = 32'h2000; aregs[15] = 32'h2001; cfgs[15] = 8'h0C;
    load_banks();
    probe("R2", PS, 34'h8000, "x", 0, 0, 0);
    probe("R2", PS, 34'h8004, "x", 0, 0, 1);
  endtask

  task automatic t_na4();
    clear_regions();
    cfgs[0] = 8'h17; aregs[0] = 32'h2000_0000;
    load_banks();
    probe("R3", PS, 34'h0_8000_0000, "x", 0, 0, 0);
    probe("R3", PS, 34'h0_8000_0002, "r", 0, 0, 0);
    probe("R3", PS, 34'h0_8000_0004, "x", 0, 0, 1);
    probe("R3", PS, 34'h0_7FFF_FFFC, "w", 0, 1, 0);
  endtask

  task automatic t_napot();
    clear_regions();
    cfgs[0] = 8'h1B; aregs[0] = 32'h1003;         // t=2 -> 32 bytes at 0x4000
    load_banks();
    probe("R4", PS, 34'h4000, "w", 0, 0, 0);
    probe("R4", PS, 34'h401C, "r", 0, 0, 0);
    probe("R4", PS, 34'h4020, "w", 0, 1, 0);
    probe("R4", PS, 34'h3FFC, "r", 1, 0, 0);
    probe("R8", PS, 34'h4000, "x", 0, 0, 1);
  endtask

  task automatic t_priority();
    clear_regions();
    cfgs[0] = 8'h11; aregs[0] = 32'h40;           // NA4 read only
    cfgs[1] = 8'h1F; aregs[1] = 32'hFFFF_FFFF;    // NAPOT everything
    load_banks();
    probe("R5", PS, 34'h100, "w", 0, 1, 0);
    probe("R5", PS, 34'h110, "w", 0, 0, 0);
    clear_regions();
    cfgs[0] = 8'h17; aregs[0] = 32'h40;
    cfgs[2] = 8'h11; aregs[2] = 32'h40;
    load_banks();
    probe("R5", PS, 34'h100, "w", 0, 0, 0);
  endtask

  task automatic t_atomic();
    clear_regions();
    cfgs[0] = 8'h14; aregs[0] = 32'h80;           // NA4 execute only
    cfgs[1] = 8'h1F; aregs[1] = 32'hFFFF_FFFF;
    load_banks();
    probe("R7", PS, 34'h200, "a", 0, 1, 0);
    probe("R6", PS, 34'h200, "r", 1, 0, 0);
    probe("R7", PS, 34'h200, "w", 0, 1, 0);
    probe("R8", PS, 34'h200, "x", 0, 0, 0);
  endtask

  task automatic t_machine();
    clear_regions();
    cfgs[0] = 8'h14; aregs[0] = 32'h80;
    load_banks();
    probe("R10", PM, 34'h200, "r", 0, 0, 0);
    probe("R10", PM, 34'h204, "w", 0, 0, 0);
    probe("R9",  PS, 34'h204, "w", 0, 1, 0);
    probe("R9",  PU, 34'h204, "x", 0, 0, 1);
    cfgs[0] = 8'h94;                               // lock set
    load_banks();
    probe("R10", PM, 34'h200, "r", 1, 0, 0);
    probe("R10", PM, 34'h200, "a", 0, 1, 0);
    probe("R10", PM, 34'h200, "x", 0, 0, 0);
    probe("R10", PM, 34'h204, "r", 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    priv_mode = PM; phys_addr = '0;
    acc_rd = 0; acc_wr = 0; acc_ex = 0;
    cfg_bank = '0; addr_bank = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_all_off();
    t_tor();
    t_na4();
    t_napot();
    t_priority();
    t_atomic();
    t_machine();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule